// File: doc/BRIEF.md
# Per-PC Stride Prefetch Predictor

This block watches the stream of data references from a processor's load and store pipeline. For each reference it takes the instruction's PC and effective address. It keeps a direct-mapped table of per-instruction records, indexed by PC. Each record learns the distance between consecutive addresses from that instruction and tracks, in a four-state confidence machine, whether that distance is dependable. From this it proposes at most one data prefetch address per reference.

A proposed address is not sent out at once. It is first held for one cycle and offered to the first-level cache through a tag-probe pair. It is discarded if the cache already holds the line. It is also discarded if the same address is already waiting in a four-slot list of outstanding prefetches, or if that list has no free slot. Surviving addresses go out on a valid/ready stream and take a slot in the list. A slot is released when the memory side reports a fill for that address.

Back-pressure rules: the reference input is accepted on `ref_valid && ref_ready`. The prefetch output offers `pf_addr` with `pf_valid` and holds both unchanged until `pf_ready`. When the output is stalled and a candidate is already waiting, `ref_ready` drops, so references stall instead of being lost.

Top module: `stride_prefetch_table`

## Requirements
- R1: After reset `pf_valid` and `probe_valid` are low and `ref_ready` is high.
- R2: The table index is `ref_pc[7:2]` at the default 64 entries, and the remaining upper PC bits form the tag. A reference whose entry is invalid or holds another tag allocates the entry in the initial state with stride 0 and last address equal to the reference address. It produces no prefetch.
- R3: A prediction is correct when the address equals last address plus stride. State codes are initial=0, steady=1, transient=2, no-prediction=3. A correct reference moves initial, transient and steady to steady, and no-prediction to transient. An incorrect one moves steady to initial, initial to transient, and transient and no-prediction to no-prediction.
- R4: On an incorrect reference the stride becomes address minus last address, except in steady, where the stride is kept. The last address becomes the reference address on every accepted reference.
- R5: After a table hit, the candidate is the reference address plus the updated stride. It is produced unless the updated state is no-prediction.
- R6: A candidate is shown on `probe_valid`/`probe_addr` from the cycle after its reference is accepted. If `probe_hit` is high in the cycle it leaves the holding stage, it is dropped.
- R7: A candidate equal to an address in the outstanding list is dropped. This includes a slot released by `fill_valid` in that same cycle.
- R8: The outstanding list holds 4 addresses. A candidate is dropped when all are in use. A fill whose address matches frees that slot, and the slot can be reused from the next cycle.
- R9: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` stay unchanged.
- R10: `ref_ready` is low only while a candidate waits and the output is stalled. A candidate accepted at one edge raises `pf_valid` at the following edge when the output is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference present |
| ref_ready | output | 1 | Reference can be accepted |
| ref_pc | input | 32 | PC of the memory instruction |
| ref_addr | input | 32 | Effective data address |
| probe_valid | output | 1 | Candidate offered to the cache tags |
| probe_addr | output | 32 | Candidate address for the tag probe |
| probe_hit | input | 1 | Cache holds `probe_addr` (same cycle) |
| pf_valid | output | 1 | Prefetch request present |
| pf_ready | input | 1 | Prefetch request taken |
| pf_addr | output | 32 | Prefetch address |
| fill_valid | input | 1 | A prefetch fill completed |
| fill_addr | input | 32 | Address of the completed fill |

## Verification
A fill returning for an address can land in the same cycle that an equal candidate leaves the holding stage. In that cycle the list both releases a slot and is asked for a duplicate match. The bench provokes this by leaving one prefetch outstanding and then training a second PC to propose the same address. It raises `fill_valid` for that address in the exact cycle the new candidate is probed. The candidate must be dropped there, and a third PC proposing the same address afterwards must be issued, which shows that the slot was released.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_STEADY = 2'd1,
    ST_TRANS  = 2'd2,
    ST_NOPRED = 2'd3
  } spt_state_e;
endpackage

// File: rtl/spt_state_next.sv
// Confidence and stride update for one table record.
module spt_state_next
  import spt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  spt_state_e        cur_state,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic [ADDR_W-1:0] cur_stride,
  input  logic [ADDR_W-1:0] addr,
  output spt_state_e        nxt_state,
  output logic [ADDR_W-1:0] nxt_stride,
  output logic              nxt_issue,
  output logic [ADDR_W-1:0] nxt_pf_addr
);
  logic              correct;
  logic [ADDR_W-1:0] delta;

  always_comb begin
    correct    = (addr == last_addr + cur_stride);
    delta      = addr - last_addr;
    nxt_state  = cur_state;
    nxt_stride = cur_stride;
    unique case (cur_state)
      ST_INIT: begin
        if (correct) nxt_state = ST_STEADY;
        else begin
          nxt_state  = ST_TRANS;
          nxt_stride = delta;
        end
      end
      ST_STEADY: begin
        if (!correct) nxt_state = ST_INIT;
      end
      ST_TRANS: begin
        if (correct) nxt_state = ST_STEADY;
        else begin
          nxt_state  = ST_NOPRED;
          nxt_stride = delta;
        end
      end
      default: begin
        if (correct) nxt_state = ST_TRANS;
        else         nxt_stride = delta;
      end
    endcase
    nxt_issue   = (nxt_state != ST_NOPRED);
    nxt_pf_addr = addr + nxt_stride;
  end
endmodule

// File: rtl/spt_table.sv
// Direct-mapped record storage, one read and one write at the same index.
module spt_table
  import spt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int PC_LSB  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pc,
  output logic              rd_hit,
  output spt_state_e        rd_state,
  output logic [ADDR_W-1:0] rd_last,
  output logic [ADDR_W-1:0] rd_stride,
  input  logic              wr_en,
  input  spt_state_e        wr_state,
  input  logic [ADDR_W-1:0] wr_last,
  input  logic [ADDR_W-1:0] wr_stride
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - PC_LSB;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  spt_state_e         state_q  [ENTRIES];
  logic [ADDR_W-1:0]  last_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;

  assign idx = pc[PC_LSB +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];

  assign rd_hit    = valid_q[idx] && (tag_q[idx] == tag);
  assign rd_state  = state_q[idx];
  assign rd_last   = last_q[idx];
  assign rd_stride = stride_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n)     valid_q      <= '0;
    else if (wr_en) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[idx]    <= tag;
      state_q[idx]  <= wr_state;
      last_q[idx]   <= wr_last;
      stride_q[idx] <= wr_stride;
    end
  end
endmodule

// File: rtl/spt_orl.sv
// Small list of prefetch addresses that are in flight.
module spt_orl #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              dup,
  output logic              full,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr
);
  logic [DEPTH-1:0]  slot_v;
  logic [ADDR_W-1:0] slot_a [DEPTH];
  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  sel;

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!slot_v[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign dup  = |match;
  assign full = &slot_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign match[g] = slot_v[g] && (slot_a[g] == chk_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[g] <= 1'b0;
        slot_a[g] <= '0;
      end else if (alloc_en && sel[g]) begin
        slot_v[g] <= 1'b1;
        slot_a[g] <= alloc_addr;
      end else if (fill_valid && slot_v[g] && slot_a[g] == fill_addr) begin
        slot_v[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stride_prefetch_table.sv
module stride_prefetch_table
  import spt_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int PC_LSB    = 2,
  parameter int ORL_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  output logic              ref_ready,
  input  logic [PC_W-1:0]   ref_pc,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_hit,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr
);
  logic              ref_fire;
  logic              tbl_hit;
  spt_state_e        tbl_state;
  logic [ADDR_W-1:0] tbl_last;
  logic [ADDR_W-1:0] tbl_stride;
  spt_state_e        nx_state;
  logic [ADDR_W-1:0] nx_stride;
  logic              nx_issue;
  logic [ADDR_W-1:0] nx_pf;
  spt_state_e        wr_state;
  logic [ADDR_W-1:0] wr_stride;

  logic              cand_valid;
  logic [ADDR_W-1:0] cand_addr;
  logic              out_free;
  logic              cand_go;
  logic              cand_pass;
  logic              orl_dup;
  logic              orl_full;

  assign out_free  = !pf_valid || pf_ready;
  assign ref_ready = !cand_valid || out_free;
  assign ref_fire  = ref_valid && ref_ready;
  assign cand_go   = cand_valid && out_free;
  assign cand_pass = cand_go && !probe_hit && !orl_dup && !orl_full;

  assign probe_valid = cand_valid;
  assign probe_addr  = cand_addr;

  spt_table #(
    .ENTRIES(ENTRIES), .PC_W(PC_W), .ADDR_W(ADDR_W), .PC_LSB(PC_LSB)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (ref_pc),
    .rd_hit   (tbl_hit),
    .rd_state (tbl_state),
    .rd_last  (tbl_last),
    .rd_stride(tbl_stride),
    .wr_en    (ref_fire),
    .wr_state (wr_state),
    .wr_last  (ref_addr),
    .wr_stride(wr_stride)
  );

  spt_state_next #(.ADDR_W(ADDR_W)) u_next (
    .cur_state  (tbl_state),
    .last_addr  (tbl_last),
    .cur_stride (tbl_stride),
    .addr       (ref_addr),
    .nxt_state  (nx_state),
    .nxt_stride (nx_stride),
    .nxt_issue  (nx_issue),
    .nxt_pf_addr(nx_pf)
  );

  // A miss allocates a fresh record in the initial state.
  assign wr_state  = tbl_hit ? nx_state  : ST_INIT;
  assign wr_stride = tbl_hit ? nx_stride : '0;

  spt_orl #(.DEPTH(ORL_DEPTH), .ADDR_W(ADDR_W)) u_orl (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_addr  (cand_addr),
    .dup       (orl_dup),
    .full      (orl_full),
    .alloc_en  (cand_pass),
    .alloc_addr(cand_addr),
    .fill_valid(fill_valid),
    .fill_addr (fill_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_valid <= 1'b0;
      cand_addr  <= '0;
    end else if (ref_fire) begin
      cand_valid <= tbl_hit && nx_issue;
      cand_addr  <= nx_pf;
    end else if (out_free) begin
      cand_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else if (cand_pass) begin
      pf_valid <= 1'b1;
      pf_addr  <= cand_addr;
    end else if (pf_ready) begin
      pf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/spt_checker.sv
module spt_checker
  import spt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_ready,
  input logic              ref_fire,
  input logic              tbl_hit,
  input spt_state_e        nx_state,
  input logic              cand_valid,
  input logic              cand_go,
  input logic              probe_hit,
  input logic              orl_dup,
  input logic              orl_full,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  p_miss_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire && !tbl_hit |=> !cand_valid);

  p_nopred_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire && tbl_hit && nx_state == ST_NOPRED |=> !cand_valid);

  p_hit_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cand_go && probe_hit |=> !pf_valid);

  p_dup_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_go && orl_dup |=> !pf_valid);

  p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cand_go && orl_full |=> !pf_valid);

  p_pf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ready |-> cand_valid && pf_valid && !pf_ready);
endmodule

bind stride_prefetch_table spt_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_stride_prefetch_table.sv
module tb_stride_prefetch_table;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_valid;
  logic        ref_ready;
  logic [31:0] ref_pc;
  logic [31:0] ref_addr;
  logic        probe_valid;
  logic [31:0] probe_addr;
  logic        probe_hit;
  logic        pf_valid;
  logic        pf_ready;
  logic [31:0] pf_addr;
  logic        fill_valid;
  logic [31:0] fill_addr;
  logic [31:0] cached_addr;

  int checks = 0;
  int errors = 0;
  logic [31:0] pf_log [64];
  int          pf_cnt = 0;
  logic [31:0] exp_a  [16];
  int          exp_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign probe_hit = probe_valid && (probe_addr == cached_addr);

  stride_prefetch_table dut (
    .clk(clk), .rst_n(rst_n),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_pc(ref_pc), .ref_addr(ref_addr),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_hit(probe_hit),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr)
  );

  // Record every prefetch handshake; inputs only change just after posedge.
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready && pf_cnt < 64) begin
      pf_log[pf_cnt] = pf_addr;
      pf_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] pc, input logic [31:0] addr);
    ref_valid = 1'b1;
    ref_pc    = pc;
    ref_addr  = addr;
    #1;
    while (!ref_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    ref_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] addr);
    fill_valid = 1'b1;
    fill_addr  = addr;
    @(posedge clk);
    #1;
    fill_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic start_log();
    pf_cnt = 0;
    exp_n  = 0;
  endtask

  task automatic want(input logic [31:0] a);
    exp_a[exp_n] = a;
    exp_n++;
  endtask

  task automatic compare_log(input string req);
    idle(4);
    chk(pf_cnt == exp_n, {req, " prefetch count"}, pf_cnt, exp_n);
    for (int i = 0; i < exp_n && i < pf_cnt; i++)
      chk(pf_log[i] == exp_a[i], {req, " prefetch address"}, pf_log[i], exp_a[i]);
  endtask

  task automatic t_reset();
    chk(pf_valid == 1'b0, "R1 pf_valid after reset", pf_valid, 0);
    chk(probe_valid == 1'b0, "R1 probe_valid after reset", probe_valid, 0);
    chk(ref_ready == 1'b1, "R1 ref_ready after reset", ref_ready, 1);
  endtask

  // R3 R5 R10: learn a stride, check pipeline latency.
  task automatic t_learn();
    start_log();
    send(32'h400, 32'd100);
    send(32'h400, 32'd108);
    chk(probe_valid && probe_addr == 32'd116, "R10 probe one cycle after accept", probe_addr, 116);
    chk(!pf_valid, "R10 pf_valid not yet raised", pf_valid, 0);
    @(posedge clk); #1;
    chk(pf_valid && pf_addr == 32'd116, "R10 pf_valid on following edge", pf_addr, 116);
    send(32'h400, 32'd116);
    send(32'h400, 32'd124);
    want(116); want(124); want(132);
    compare_log("R5");
    fill(116); fill(124); fill(132);
  endtask

  // R3 R4: every transition, stride kept in steady miss.
  task automatic t_states();
    start_log();
    send(32'h400, 32'd200);   // steady wrong -> init, stride 8 kept
    send(32'h400, 32'd300);   // init wrong -> transient, stride 100
    send(32'h400, 32'd350);   // transient wrong -> no-pred, stride 50
    send(32'h400, 32'd400);   // no-pred correct -> transient
    send(32'h400, 32'd437);   // transient wrong -> no-pred, stride 37
    send(32'h400, 32'd1000);  // no-pred wrong -> no-pred
    send(32'h400, 32'd1563);  // no-pred correct (stride 563) -> transient
    want(208); want(400); want(450); want(2126);
    compare_log("R3 R4");
    fill(208); fill(400); fill(450); fill(2126);
  endtask

  // R2: tag conflict at the same index replaces the record.
  task automatic t_replace();
    start_log();
    send(32'h800, 32'd132);
    send(32'h400, 32'd140);
    send(32'h400, 32'd148);
    want(156);
    compare_log("R2");
    fill(156);
  endtask

  // R6: candidate already cached is dropped.
  task automatic t_probe();
    start_log();
    cached_addr = 32'd520;
    send(32'h404, 32'd500);
    send(32'h404, 32'd510);
    send(32'h404, 32'd520);
    want(530);
    compare_log("R6");
    cached_addr = 32'hffff_ffff;
    fill(530);
  endtask

  // R7: duplicate of an outstanding request is not reissued.
  task automatic t_dup();
    start_log();
    send(32'h408, 32'd600);
    send(32'h408, 32'd604);
    send(32'h40c, 32'd600);
    send(32'h40c, 32'd604);
    idle(3);
    fill(608);
    send(32'h40c, 32'd608);
    want(608); want(612);
    compare_log("R7");
    fill(612);
  endtask

  // R8: full list drops, a fill frees a slot.
  task automatic t_full();
    start_log();
    for (int i = 0; i < 6; i++) send(32'h410, 32'd4096 + 32'(16 * i));
    idle(3);
    fill(4096 + 32);
    send(32'h410, 32'd4096 + 32'd96);
    want(4128); want(4144); want(4160); want(4176); want(4208);
    compare_log("R8");
    fill(4144); fill(4160); fill(4176); fill(4208);
  endtask

  // R9 R10: stalled output holds and blocks references.
  task automatic t_backpressure();
    start_log();
    pf_ready = 1'b0;
    send(32'h414, 32'd2000);
    send(32'h414, 32'd2004);
    idle(1);
    for (int i = 0; i < 3; i++) begin
      chk(pf_valid && pf_addr == 32'd2008, "R9 held while stalled", pf_addr, 2008);
      idle(1);
    end
    send(32'h414, 32'd2008);
    chk(ref_ready == 1'b0, "R10 ref_ready low when both stages full", ref_ready, 0);
    chk(pf_addr == 32'd2008, "R9 address unchanged", pf_addr, 2008);
    pf_ready = 1'b1;
    want(2008); want(2012);
    compare_log("R9");
    chk(ref_ready == 1'b1, "R10 ref_ready back high", ref_ready, 1);
    fill(2008); fill(2012);
  endtask

  // R7 R8: fill and equal candidate in the same cycle.
  task automatic t_fill_race();
    start_log();
    send(32'h418, 32'd3000);
    send(32'h418, 32'd3008);   // 3016 outstanding
    idle(2);
    send(32'h41c, 32'd3000);
    send(32'h41c, 32'd3008);   // candidate 3016 is probed now
    fill_valid = 1'b1;
    fill_addr  = 32'd3016;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    send(32'h41c, 32'd3016);
    send(32'h420, 32'd3000);
    send(32'h420, 32'd3008);
    want(3016); want(3024); want(3016);
    compare_log("R7 R8 same-cycle fill");
  endtask

  initial begin
    rst_n       = 1'b0;
    ref_valid   = 1'b0;
    ref_pc      = '0;
    ref_addr    = '0;
    pf_ready    = 1'b1;
    fill_valid  = 1'b0;
    fill_addr   = '0;
    cached_addr = 32'hffff_ffff;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_learn();
    t_states();
    t_replace();
    t_probe();
    t_dup();
    t_full();
    t_backpressure();
    t_fill_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule